// File: doc/BRIEF.md
# AXI Write Address Command Sequencer

This block plays out a programmed run of AXI4 write-address transactions for a traffic generator. A one-cycle start pulse captures the whole configuration: how many transactions, a start delay, the first address, the address stepping rule, an address window, the burst length, size and type, and how the ID is chosen. After the delay the block raises the AW-channel valid and keeps the request steady until the slave accepts it. It then moves straight on to the next request, without a gap, until the run is complete.

Each transaction starts at the previous start address plus a step. The step is either a programmed stride or the byte span of one burst. A step that would carry past the top of the window sends the next request to the window base instead. The ID is either one fixed value or a counter that starts at zero. In every accepted cycle the block hands the start address, length and size to a separate write-data beat generator. One pulse marks the end of the run.

Top module: `aw_cmd_seq`

## Requirements
- R1: With a transaction count of n, exactly n AW handshakes occur. `done_o` is high for exactly the one cycle after the last handshake. A count of 0 gives no handshake and pulses `done_o` in the cycle after start.
- R2: With a start delay of D and a nonzero count, `aw_valid_o` first goes high D cycles after the clock edge that samples `start_i`, where 0 means the very next cycle.
- R3: While `aw_valid_o` is high and `aw_ready_i` is low, `aw_valid_o` stays high and the address, ID, length, size and burst outputs hold their values into the next cycle.
- R4: In stride mode (`cfg_addr_mode_i`=0) each later start address is the previous start address plus `cfg_addr_incr_i`. A stride of 0 repeats the first address.
- R5: In burst-span mode (`cfg_addr_mode_i`=1) each later start address is the previous one plus (len+1) shifted left by size. With size 6 and len 0, a run from 0 gives 0x00, 0x40, 0x80.
- R6: When the stepped address is greater than `cfg_high_addr_i`, or carries out of the address width, the next transaction starts at `cfg_base_addr_i`. A stepped address equal to the high bound is used as it is.
- R7: With `cfg_id_mode_i`=0 every transaction carries `cfg_id_i`. With `cfg_id_mode_i`=1 the IDs are 0, 1, 2, and so on, modulo 2^ID_W.
- R8: `aw_len_o`, `aw_size_o` and `aw_burst_o` carry the captured length, size and burst codes unchanged (burst 1 = INCR, 2 = WRAP).
- R9: Lock, prot, qos, region and user are driven to 0, and cache is driven to 2.
- R10: `beat_valid_o` is high in exactly the cycles in which a handshake occurs. In those cycles `beat_addr_o`, `beat_len_o` and `beat_size_o` equal the accepted request's address, length and size.
- R11: The configuration is captured only at an accepted start. A `start_i` pulse while busy, including one in the cycle of the final handshake, starts nothing. Configuration inputs that change during a run do not affect it.
- R12: `busy_o` is high from the cycle after an accepted start with nonzero count until the last handshake, and low in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, captures configuration when idle |
| cfg_txn_count_i | input | CNT_W | Number of transactions |
| cfg_start_delay_i | input | DLY_W | Cycles before the first request |
| cfg_addr_mode_i | input | 1 | 0 stride, 1 burst-span stepping |
| cfg_addr_incr_i | input | ADDR_W | Stride in stride mode |
| cfg_start_addr_i | input | ADDR_W | First start address |
| cfg_base_addr_i | input | ADDR_W | Window base, wrap target |
| cfg_high_addr_i | input | ADDR_W | Window top bound |
| cfg_len_i | input | 8 | Burst length code |
| cfg_size_i | input | 3 | Burst size code |
| cfg_burst_i | input | 2 | Burst type code |
| cfg_id_mode_i | input | 1 | 0 fixed ID, 1 counting ID |
| cfg_id_i | input | ID_W | Fixed ID value |
| aw_ready_i | input | 1 | AW ready from slave |
| aw_valid_o | output | 1 | AW valid |
| aw_addr_o | output | ADDR_W | AW address |
| aw_id_o | output | ID_W | AW ID |
| aw_len_o | output | 8 | AW length |
| aw_size_o | output | 3 | AW size |
| aw_burst_o | output | 2 | AW burst type |
| aw_lock_o | output | 1 | AW lock, tied 0 |
| aw_cache_o | output | 4 | AW cache, tied 2 |
| aw_prot_o | output | 3 | AW prot, tied 0 |
| aw_qos_o | output | 4 | AW qos, tied 0 |
| aw_region_o | output | 4 | AW region, tied 0 |
| aw_user_o | output | USER_W | AW user, tied 0 |
| beat_valid_o | output | 1 | Handoff strobe to data-beat generator |
| beat_addr_o | output | ADDR_W | Handoff start address |
| beat_len_o | output | 8 | Handoff length |
| beat_size_o | output | 3 | Handoff size |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete pulse |

## Verification
The final handshake and a fresh `start_i` can land on the same clock edge. The bench raises `start_i` in exactly the cycle where it sees the last request accepted, with a changed configuration. It then requires a single `done_o` one cycle later and a silent AW channel for several idle cycles after that. The address-window wrap can also coincide with a stalled handshake. Random back-pressure holds requests across the cycle where the wrapped address would be computed, and the bench judges that the held address stays put and the base appears only on the request that follows.

// File: rtl/aw_seq_pkg.sv
package aw_seq_pkg;

  typedef enum logic {
    ADDR_STRIDE = 1'b0,
    ADDR_SPAN   = 1'b1
  } addr_mode_e;

  typedef enum logic {
    ID_FIXED = 1'b0,
    ID_COUNT = 1'b1
  } id_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2
  } seq_state_e;

  localparam logic [3:0] AW_CACHE_DEFAULT = 4'd2;

endpackage

// File: rtl/aw_seq_delay.sv
module aw_seq_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             last_o
);

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= delay_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - DLY_W'(1);
  end

  // last waiting cycle: the state moves on at the next edge
  assign last_o = (cnt_q <= DLY_W'(1));

endmodule

// File: rtl/aw_seq_addr_gen.sv
module aw_seq_addr_gen
  import aw_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  addr_mode_e        mode_i,
  input  logic [ADDR_W-1:0] incr_i,
  input  logic [7:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] high_i,
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              wrap_o
);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W:0]   sum;

  always_comb begin
    span   = (ADDR_W'(len_i) + ADDR_W'(1)) << size_i;
    step   = (mode_i == ADDR_SPAN) ? span : incr_i;
    sum    = {1'b0, cur_i} + {1'b0, step};
    wrap_o = sum[ADDR_W] || (sum[ADDR_W-1:0] > high_i);
    nxt_o  = wrap_o ? base_i : sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/aw_seq_id_gen.sv
module aw_seq_id_gen
  import aw_seq_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  id_mode_e        mode_i,
  input  logic [ID_W-1:0] fixed_i,
  input  logic [ID_W-1:0] cur_i,
  output logic [ID_W-1:0] nxt_o
);

  assign nxt_o = (mode_i == ID_COUNT) ? cur_i + ID_W'(1) : fixed_i;

endmodule

// File: rtl/aw_cmd_seq.sv
module aw_cmd_seq
  import aw_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 6,
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 16,
  parameter int USER_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cfg_txn_count_i,
  input  logic [DLY_W-1:0]  cfg_start_delay_i,
  input  logic              cfg_addr_mode_i,
  input  logic [ADDR_W-1:0] cfg_addr_incr_i,
  input  logic [ADDR_W-1:0] cfg_start_addr_i,
  input  logic [ADDR_W-1:0] cfg_base_addr_i,
  input  logic [ADDR_W-1:0] cfg_high_addr_i,
  input  logic [7:0]        cfg_len_i,
  input  logic [2:0]        cfg_size_i,
  input  logic [1:0]        cfg_burst_i,
  input  logic              cfg_id_mode_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic              aw_ready_i,
  output logic              aw_valid_o,
  output logic [ADDR_W-1:0] aw_addr_o,
  output logic [ID_W-1:0]   aw_id_o,
  output logic [7:0]        aw_len_o,
  output logic [2:0]        aw_size_o,
  output logic [1:0]        aw_burst_o,
  output logic              aw_lock_o,
  output logic [3:0]        aw_cache_o,
  output logic [2:0]        aw_prot_o,
  output logic [3:0]        aw_qos_o,
  output logic [3:0]        aw_region_o,
  output logic [USER_W-1:0] aw_user_o,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [7:0]        beat_len_o,
  output logic [2:0]        beat_size_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [ID_W-1:0]   id_q, nxt_id, first_id;
  logic              done_q, dly_last, addr_wrap, accept, hs, last_hs;

  addr_mode_e        am_q;
  id_mode_e          im_q;
  logic [ADDR_W-1:0] incr_q, base_q, high_q;
  logic [7:0]        len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ID_W-1:0]   fid_q;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign hs       = (state_q == ST_ISSUE) && aw_ready_i;
  assign last_hs  = hs && (rem_q == CNT_W'(1));
  assign first_id = (id_mode_e'(cfg_id_mode_i) == ID_COUNT) ? '0 : cfg_id_i;

  aw_seq_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .delay_i (cfg_start_delay_i),
    .last_o  (dly_last)
  );

  aw_seq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .mode_i (am_q),
    .incr_i (incr_q),
    .len_i  (len_q),
    .size_i (size_q),
    .base_i (base_q),
    .high_i (high_q),
    .cur_i  (addr_q),
    .nxt_o  (nxt_addr),
    .wrap_o (addr_wrap)
  );

  aw_seq_id_gen #(.ID_W(ID_W)) u_id (
    .mode_i  (im_q),
    .fixed_i (fid_q),
    .cur_i   (id_q),
    .nxt_o   (nxt_id)
  );

  // configuration capture, only on an accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_q    <= ADDR_SPAN;
      im_q    <= ID_COUNT;
      incr_q  <= '0;
      base_q  <= '0;
      high_q  <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= 2'd1;
      fid_q   <= '0;
    end else if (accept) begin
      am_q    <= addr_mode_e'(cfg_addr_mode_i);
      im_q    <= id_mode_e'(cfg_id_mode_i);
      incr_q  <= cfg_addr_incr_i;
      base_q  <= cfg_base_addr_i;
      high_q  <= cfg_high_addr_i;
      len_q   <= cfg_len_i;
      size_q  <= cfg_size_i;
      burst_q <= cfg_burst_i;
      fid_q   <= cfg_id_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      id_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            rem_q  <= cfg_txn_count_i;
            addr_q <= cfg_start_addr_i;
            id_q   <= first_id;
            if (cfg_txn_count_i == '0)         done_q  <= 1'b1;
            else if (cfg_start_delay_i == '0)  state_q <= ST_ISSUE;
            else                               state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dly_last) state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (last_hs) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (hs) begin
            rem_q  <= rem_q - CNT_W'(1);
            addr_q <= nxt_addr;
            id_q   <= nxt_id;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign aw_valid_o   = (state_q == ST_ISSUE);
  assign aw_addr_o    = addr_q;
  assign aw_id_o      = id_q;
  assign aw_len_o     = len_q;
  assign aw_size_o    = size_q;
  assign aw_burst_o   = burst_q;
  assign aw_lock_o    = 1'b0;
  assign aw_cache_o   = AW_CACHE_DEFAULT;
  assign aw_prot_o    = '0;
  assign aw_qos_o     = '0;
  assign aw_region_o  = '0;
  assign aw_user_o    = '0;

  assign beat_valid_o = hs;
  assign beat_addr_o  = addr_q;
  assign beat_len_o   = len_q;
  assign beat_size_o  = size_q;

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R3
  aw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o && !aw_ready_i |=> aw_valid_o && $stable(aw_addr_o) && $stable(aw_id_o)
      && $stable(aw_len_o) && $stable(aw_size_o) && $stable(aw_burst_o));

  // R1
  done_after_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(busy_o) |-> $past(aw_valid_o && aw_ready_i));

  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aw_valid_o) |-> $past(state_q == ST_WAIT || (state_q == ST_IDLE && start_i)));

  // R7
  id_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !last_hs && im_q == ID_COUNT |=> aw_id_o == ID_W'($past(aw_id_o) + ID_W'(1)));

  // R6
  wrap_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !last_hs && addr_wrap |=> aw_addr_o == base_q);

  // R11
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(len_q) && $stable(high_q) && $stable(am_q));

endmodule

// File: tb/aw_cmd_seq_tb.sv
module aw_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 6;
  localparam int CNT_W  = 16;
  localparam int DLY_W  = 16;
  localparam int USER_W = 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  cfg_txn_count_i = '0;
  logic [DLY_W-1:0]  cfg_start_delay_i = '0;
  logic              cfg_addr_mode_i = 1'b1;
  logic [ADDR_W-1:0] cfg_addr_incr_i = '0;
  logic [ADDR_W-1:0] cfg_start_addr_i = '0;
  logic [ADDR_W-1:0] cfg_base_addr_i = '0;
  logic [ADDR_W-1:0] cfg_high_addr_i = '0;
  logic [7:0]        cfg_len_i = '0;
  logic [2:0]        cfg_size_i = '0;
  logic [1:0]        cfg_burst_i = 2'd1;
  logic              cfg_id_mode_i = 1'b1;
  logic [ID_W-1:0]   cfg_id_i = '0;
  logic              aw_ready_i = 1'b0;
  logic              aw_valid_o;
  logic [ADDR_W-1:0] aw_addr_o;
  logic [ID_W-1:0]   aw_id_o;
  logic [7:0]        aw_len_o;
  logic [2:0]        aw_size_o;
  logic [1:0]        aw_burst_o;
  logic              aw_lock_o;
  logic [3:0]        aw_cache_o;
  logic [2:0]        aw_prot_o;
  logic [3:0]        aw_qos_o;
  logic [3:0]        aw_region_o;
  logic [USER_W-1:0] aw_user_o;
  logic              beat_valid_o;
  logic [ADDR_W-1:0] beat_addr_o;
  logic [7:0]        beat_len_o;
  logic [2:0]        beat_size_o;
  logic              busy_o;
  logic              done_o;

  aw_cmd_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .USER_W(USER_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .cfg_txn_count_i(cfg_txn_count_i), .cfg_start_delay_i(cfg_start_delay_i),
    .cfg_addr_mode_i(cfg_addr_mode_i), .cfg_addr_incr_i(cfg_addr_incr_i),
    .cfg_start_addr_i(cfg_start_addr_i), .cfg_base_addr_i(cfg_base_addr_i),
    .cfg_high_addr_i(cfg_high_addr_i), .cfg_len_i(cfg_len_i), .cfg_size_i(cfg_size_i),
    .cfg_burst_i(cfg_burst_i), .cfg_id_mode_i(cfg_id_mode_i), .cfg_id_i(cfg_id_i),
    .aw_ready_i(aw_ready_i), .aw_valid_o(aw_valid_o), .aw_addr_o(aw_addr_o),
    .aw_id_o(aw_id_o), .aw_len_o(aw_len_o), .aw_size_o(aw_size_o), .aw_burst_o(aw_burst_o),
    .aw_lock_o(aw_lock_o), .aw_cache_o(aw_cache_o), .aw_prot_o(aw_prot_o),
    .aw_qos_o(aw_qos_o), .aw_region_o(aw_region_o), .aw_user_o(aw_user_o),
    .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o), .beat_len_o(beat_len_o),
    .beat_size_o(beat_size_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  // run configuration
  int unsigned       c_cnt, c_dly, c_rdy;
  bit                c_am, c_im, c_late_start;
  logic [ADDR_W-1:0] c_inc, c_sa, c_base, c_high;
  logic [7:0]        c_len;
  logic [2:0]        c_size;
  logic [1:0]        c_burst;
  logic [ID_W-1:0]   c_id;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_next(input logic [ADDR_W-1:0] cur);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W:0]   sum;
    step = c_am ? ((ADDR_W'(c_len) + ADDR_W'(1)) << c_size) : c_inc;
    sum  = {1'b0, cur} + {1'b0, step};
    if (sum[ADDR_W] || sum[ADDR_W-1:0] > c_high) return c_base;
    return sum[ADDR_W-1:0];
  endfunction

  task automatic run();
    int unsigned       k = 0;
    int                first_v = -1;
    int                last_hs_it = -1;
    bit                got_done = 0;
    bit                prev_stall = 0;
    logic [ADDR_W-1:0] e_addr = c_sa;
    logic [ADDR_W-1:0] p_addr = '0;
    logic [ID_W-1:0]   p_id = '0;
    logic [ID_W-1:0]   e_id;
    e_id = c_im ? '0 : c_id;
    @(negedge clk_i);
    cfg_txn_count_i   = CNT_W'(c_cnt);
    cfg_start_delay_i = DLY_W'(c_dly);
    cfg_addr_mode_i   = c_am;
    cfg_addr_incr_i   = c_inc;
    cfg_start_addr_i  = c_sa;
    cfg_base_addr_i   = c_base;
    cfg_high_addr_i   = c_high;
    cfg_len_i         = c_len;
    cfg_size_i        = c_size;
    cfg_burst_i       = c_burst;
    cfg_id_mode_i     = c_im;
    cfg_id_i          = c_id;
    start_i           = 1'b1;
    aw_ready_i        = 1'b0;
    for (int it = 0; it < 3000; it++) begin
      bit hs;
      @(negedge clk_i);
      start_i = 1'b0;
      if (c_late_start && it == 0) begin
        // R11: scramble inputs after capture
        cfg_len_i       = ~c_len;
        cfg_size_i      = c_size + 3'd1;
        cfg_high_addr_i = '0;
        cfg_addr_incr_i = c_inc + 32'h10;
        cfg_id_i        = c_id + 1'b1;
        cfg_burst_i     = 2'd3;
      end
      aw_ready_i = ($urandom_range(99) < c_rdy);
      #1;
      hs = aw_valid_o && aw_ready_i;
      if (done_o) begin
        got_done = 1;
        chk(k == c_cnt, "R1", "handshakes at done", 64'(k), 64'(c_cnt));
        if (c_cnt == 0) chk(it == 0, "R1", "done cycle for zero count", 64'(it), 0);
        else chk(it == last_hs_it + 1, "R1", "done cycle", 64'(it), 64'(last_hs_it + 1));
        chk(!busy_o, "R12", "busy at done", 64'(busy_o), 0);
        chk(!aw_valid_o, "R1", "valid at done", 64'(aw_valid_o), 0);
        break;
      end
      chk(busy_o == (c_cnt != 0), "R12", "busy during run", 64'(busy_o), 64'(c_cnt != 0));
      if (aw_valid_o && first_v < 0) begin
        first_v = it;
        chk(it == int'(c_dly), "R2", "first valid cycle", 64'(it), 64'(c_dly));
      end
      if (prev_stall) begin
        chk(aw_valid_o, "R3", "valid dropped in stall", 64'(aw_valid_o), 1);
        chk(aw_addr_o == p_addr && aw_id_o == p_id, "R3", "fields moved in stall",
            {aw_id_o, aw_addr_o}, {p_id, p_addr});
      end
      chk(beat_valid_o == hs, "R10", "beat strobe", 64'(beat_valid_o), 64'(hs));
      if (hs) begin
        chk(aw_addr_o == e_addr, c_am ? "R5/R6" : "R4/R6", "address", aw_addr_o, e_addr);
        chk(aw_id_o == e_id, "R7", "id", 64'(aw_id_o), 64'(e_id));
        chk({aw_len_o, aw_size_o, aw_burst_o} == {c_len, c_size, c_burst}, "R8", "len/size/burst",
            64'({aw_len_o, aw_size_o, aw_burst_o}), 64'({c_len, c_size, c_burst}));
        chk({aw_lock_o, aw_prot_o, aw_qos_o, aw_region_o, aw_user_o} == '0 && aw_cache_o == 4'd2,
            "R9", "side fields", 64'({aw_cache_o, aw_lock_o, aw_prot_o, aw_qos_o, aw_region_o}),
            64'({4'd2, 12'd0}));
        chk(beat_addr_o == e_addr && beat_len_o == c_len && beat_size_o == c_size, "R10",
            "beat payload", 64'({beat_len_o, beat_size_o, beat_addr_o}),
            64'({c_len, c_size, e_addr}));
        k++;
        last_hs_it = it;
        e_addr = exp_next(e_addr);
        e_id = c_im ? e_id + 1'b1 : c_id;
        // R11: collide a new start with the final handshake
        if (c_late_start && k == c_cnt) begin
          cfg_txn_count_i = CNT_W'(c_cnt + 4);
          start_i = 1'b1;
        end
      end
      prev_stall = aw_valid_o && !aw_ready_i;
      p_addr = aw_addr_o;
      p_id = aw_id_o;
    end
    if (!got_done) chk(0, "R1", "run never finished", 64'(k), 64'(c_cnt));
    if (c_late_start) begin
      for (int j = 0; j < 5; j++) begin
        @(negedge clk_i);
        start_i = 1'b0;
        #1;
        chk(!aw_valid_o && !busy_o, "R11", "activity after ignored start",
            64'({aw_valid_o, busy_o}), 0);
      end
    end
    aw_ready_i = 1'b0;
    c_late_start = 0;
  endtask

  task automatic set_defaults();
    c_cnt = 3; c_dly = 0; c_rdy = 100; c_am = 1; c_im = 1; c_late_start = 0;
    c_inc = '0; c_sa = '0; c_base = '0; c_high = 32'hFFFF_FFFF;
    c_len = 8'd0; c_size = 3'd6; c_burst = 2'd1; c_id = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk_i);
    #1;
    chk(!aw_valid_o && !busy_o && !done_o && !beat_valid_o, "R12", "reset outputs",
        64'({aw_valid_o, busy_o, done_o, beat_valid_o}), 0);
    rst_ni = 1'b1;

    // R5: span stepping 0x00, 0x40, 0x80
    set_defaults();
    run();

    // R4: zero stride repeats, fixed id
    set_defaults();
    c_am = 0; c_inc = '0; c_sa = 32'h1230; c_cnt = 4; c_im = 0; c_id = 6'd5; c_burst = 2'd2;
    run();

    // R6: wrap to base, equal-to-high kept, with stalls
    set_defaults();
    c_am = 0; c_inc = 32'h40; c_sa = 32'h100; c_base = 32'h100; c_high = 32'h180;
    c_cnt = 7; c_rdy = 50;
    run();

    // R1: zero count
    set_defaults();
    c_cnt = 0; c_dly = 4;
    run();

    // R2: long delay with back-pressure
    set_defaults();
    c_dly = 9; c_rdy = 40; c_cnt = 5; c_len = 8'd3; c_size = 3'd2;
    run();

    // R6: carry out of the address width
    set_defaults();
    c_am = 0; c_sa = 32'hFFFF_FFC0; c_inc = 32'h80; c_base = 32'h2000; c_cnt = 3;
    run();

    // R11: start collides with last handshake, inputs change mid-run
    set_defaults();
    c_cnt = 4; c_dly = 2; c_late_start = 1; c_im = 0; c_id = 6'd9;
    run();

    // R7: id wraps modulo 2^ID_W
    set_defaults();
    c_cnt = 70; c_size = 3'd0;
    run();

    for (int r = 0; r < 24; r++) begin
      logic [ADDR_W-1:0] span_w;
      set_defaults();
      c_cnt   = $urandom_range(12, 1);
      c_dly   = $urandom_range(9);
      c_rdy   = $urandom_range(100, 30);
      c_am    = 1'($urandom_range(1));
      c_im    = 1'($urandom_range(1));
      c_len   = 8'($urandom_range(15));
      c_size  = 3'($urandom_range(7));
      c_burst = 2'($urandom_range(2, 1));
      c_id    = ID_W'($urandom);
      c_inc   = 32'($urandom_range(4095)) & 32'hFF0;
      c_base  = 32'($urandom) & 32'hFFFF_0000;
      span_w  = 32'($urandom_range(8192, 64));
      c_high  = c_base + span_w;
      c_sa    = c_base + (32'($urandom) % span_w);
      c_late_start = (r % 5 == 4) && (c_cnt >= 2);
      run();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule